// File: doc/BRIEF.md
# Transaction-Layer Packet Receive Dispatcher

This block sits behind a PCIe core's receive port. It takes transaction layer packets one 32-bit double word (DW) per beat over a valid/ready stream with a last-beat marker. For each packet it decodes the format and type byte of the first header DW and collects the remaining header DWs. It checks the packet against three register address windows and against its own framing rules. Only then does it act on the packet.

A one-DW memory write into a window becomes a single-cycle register write strobe with offset, data, byte enables and window code. A memory read into a window becomes a request descriptor for the completion transmit side. The descriptor is held, with the input stalled, until that side accepts it. A completion with data has its payload streamed straight through to a DMA port, with input backpressure taken from that port. Unsupported or misframed packets are drained up to their last beat, and one of two single-cycle flags marks each of them.

Top module: `tlp_rx_dispatch`

## Requirements
- R1: After reset `inReady` is 1, and `descValid`, `regWrEn`, `dmaValid`, `unsupPulse` and `malformPulse` are 0.
- R2: The accepted codes of DW0 bits [31:24] are 0x00 and 0x20 (read, 3DW/4DW), 0x40 and 0x60 (write, 3DW/4DW), and 0x4A (completion with data, 3DW). Any other code gives `unsupPulse` high for one cycle after the DW0 beat, and the rest of the packet is consumed with no other effect.
- R3: A write into a window that has length field DW0[9:0]=1 and exactly one data beat (marked last) gives `regWrEn` high for exactly one cycle, the cycle after the data beat. `regWrData` is the data beat. `regWrBe` is DW1[3:0]. `regWrAddr` is the address bits [WIN_BITS-1:2] followed by two zero bits.
- R4: A write into a window whose length is not 1 gives `malformPulse` and no register write.
- R5: A read into a window gives a descriptor with these fields: `descReqId`=DW1[31:16], `descTag`=DW1[15:8], `descTc`=DW0[22:20], `descAttr`=DW0[13:12], `descLenDw`=DW0[9:0], `descOffset`=the window offset with bits [1:0] zero. `descLowAddr` is address bits [6:2] followed by the index of the lowest set bit of DW1[3:0] (0 if none).
- R6: While `descValid` is 1, `inReady` is 0 and the descriptor fields are stable. `descValid` falls in the cycle after the handshake with `descReady`.
- R7: Three windows of 2^WIN_BITS bytes are decoded at BAR0_BASE, BAR2_BASE and BAR4_BASE, with window codes 0, 2 and 4 on `regWrBar`/`descBar`. A read or write outside all three windows gives `unsupPulse` and no action.
- R8: A 3DW request (fmt bit 29 = 0) takes its address from DW2 with the upper 32 bits zero. A 4DW request takes address bits [63:32] from DW2 and bits [31:0] from DW3.
- R9: The payload beats of a completion appear on `dmaData`/`dmaLast` in order. Each input beat is accepted only when `dmaReady` is 1. `dmaTag` is DW2[15:8] of the completion header.
- R10: A packet whose last beat comes before its header ends, or before a required payload, or after a read header or a single write data beat, gives `malformPulse`. It is drained with no write, descriptor or DMA beat.
- R11: The engine looks for a new header only after the last beat of the current packet has been consumed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inData | input | 32 | Packet DW of the current beat |
| inValid | input | 1 | Beat valid |
| inLast | input | 1 | Final beat of the packet |
| inReady | output | 1 | Beat accepted when high with inValid |
| regWrEn | output | 1 | One-cycle register write strobe |
| regWrAddr | output | WIN_BITS | Byte offset within the window |
| regWrData | output | 32 | Write data |
| regWrBe | output | 4 | Byte enables |
| regWrBar | output | 3 | Window code 0, 2 or 4 |
| descValid | output | 1 | Read descriptor pending |
| descReady | input | 1 | Transmit side takes the descriptor |
| descReqId | output | 16 | Requester ID |
| descTag | output | 8 | Request tag |
| descTc | output | 3 | Traffic class |
| descAttr | output | 2 | Attributes |
| descLenDw | output | 10 | Requested length in DW |
| descLowAddr | output | 7 | Lower byte address for the completion |
| descOffset | output | WIN_BITS | Byte offset within the window |
| descBar | output | 3 | Window code 0, 2 or 4 |
| dmaValid | output | 1 | Completion payload beat valid |
| dmaReady | input | 1 | DMA engine takes the beat |
| dmaData | output | 32 | Payload DW |
| dmaLast | output | 1 | Final payload beat |
| dmaTag | output | 8 | Tag of the completion |
| unsupPulse | output | 1 | Unsupported type or window miss |
| malformPulse | output | 1 | Framing or length error |

## Verification
The main sweep sends all 256 values of the format/type byte. Each value gets a packet framed as its format bits imply: 3 or 4 header DWs, plus one payload DW when the data bit is set. This separates the five accepted codes from every near neighbour, and each accepted code must give exactly its own outcome: descriptor, write, DMA beat or flag. Directed packets then cover the following:
- window edges just outside a window, and 64-bit addressing that only a 4DW header can reach;
- multi-DW writes, packets cut short, packets with extra beats, and a drained packet whose payload looks like a header;
- a held descriptor with a delayed acknowledge, where every field is compared;
- a multi-beat completion under a stalling `dmaReady`, which shows beat order, the last marker and the tag.

// File: rtl/tlp_rx_pkg.sv
package tlp_rx_pkg;
  localparam int DW_BITS = 32;

  typedef enum logic [1:0] {K_MRD, K_MWR, K_CPLD, K_BAD} kind_e;

  // control -> datapath strobes
  typedef struct packed {
    logic capDw0;
    logic capDw1;
    logic capDw2;
    logic capDecide;
    logic fireWr;
    logic flagUnsup;
    logic flagMal;
    logic passCpl;
  } ctl_t;

  function automatic kind_e classify(input logic [7:0] fmtType);
    case (fmtType)
      8'h00, 8'h20: classify = K_MRD;
      8'h40, 8'h60: classify = K_MWR;
      8'h4A:        classify = K_CPLD;
      default:      classify = K_BAD;
    endcase
  endfunction

  function automatic logic [1:0] beOffset(input logic [3:0] be);
    if (be[0])      beOffset = 2'd0;
    else if (be[1]) beOffset = 2'd1;
    else if (be[2]) beOffset = 2'd2;
    else if (be[3]) beOffset = 2'd3;
    else            beOffset = 2'd0;
  endfunction
endpackage

// File: rtl/tlp_rx_datapath.sv
module tlp_rx_datapath
  import tlp_rx_pkg::*;
#(
  parameter int          WIN_BITS  = 12,
  parameter logic [63:0] BAR0_BASE = 64'h0000_0000_F000_0000,
  parameter logic [63:0] BAR2_BASE = 64'h0000_0000_F001_0000,
  parameter logic [63:0] BAR4_BASE = 64'h0000_0010_0000_0000
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctl_t                ctl,
  input  logic [DW_BITS-1:0]  inData,
  input  logic                inValid,
  input  logic                inLast,
  output kind_e               curKind,
  output kind_e               hdrKind,
  output logic                hdr4dw,
  output logic                lenIsOne,
  output logic                anyHit,
  output logic                regWrEn,
  output logic [WIN_BITS-1:0] regWrAddr,
  output logic [DW_BITS-1:0]  regWrData,
  output logic [3:0]          regWrBe,
  output logic [2:0]          regWrBar,
  output logic [15:0]         descReqId,
  output logic [7:0]          descTag,
  output logic [2:0]          descTc,
  output logic [1:0]          descAttr,
  output logic [9:0]          descLenDw,
  output logic [6:0]          descLowAddr,
  output logic [WIN_BITS-1:0] descOffset,
  output logic [2:0]          descBar,
  output logic                dmaValid,
  output logic [DW_BITS-1:0]  dmaData,
  output logic                dmaLast,
  output logic [7:0]          dmaTag,
  output logic                unsupPulse,
  output logic                malformPulse
);
  localparam int NWIN = 3;
  localparam logic [NWIN-1:0][63:0] BASES = {BAR4_BASE, BAR2_BASE, BAR0_BASE};

  logic [DW_BITS-1:0] dw0Q, dw1Q, dw2Q;
  logic [63:0]        curAddr;
  logic [NWIN-1:0]    hitVec;
  logic [2:0]         barCode;
  logic [WIN_BITS-1:0] offQ;
  logic [2:0]         barQ;
  logic [6:0]         lowQ;
  logic [3:0]         beQ;
  logic [7:0]         cplTagQ;

  assign curKind  = classify(inData[31:24]);
  assign hdrKind  = classify(dw0Q[31:24]);
  assign hdr4dw   = dw0Q[29];
  assign lenIsOne = (dw0Q[9:0] == 10'd1);

  // address of the final header beat: upper half stored for 4DW, zero for 3DW
  assign curAddr = hdr4dw ? {dw2Q, inData} : {32'b0, inData};

  for (genvar w = 0; w < NWIN; w++) begin : g_win
    assign hitVec[w] = (curAddr[63:WIN_BITS] == BASES[w][63:WIN_BITS]);
  end

  assign anyHit = |hitVec;

  // lowest window wins if windows overlap
  always_comb begin
    barCode = 3'd4;
    if (hitVec[1]) barCode = 3'd2;
    if (hitVec[0]) barCode = 3'd0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dw0Q <= '0;
      dw1Q <= '0;
      dw2Q <= '0;
      offQ <= '0;
      barQ <= '0;
      lowQ <= '0;
      beQ <= '0;
      cplTagQ <= '0;
    end else begin
      if (ctl.capDw0) dw0Q <= inData;
      if (ctl.capDw1) dw1Q <= inData;
      if (ctl.capDw2) dw2Q <= inData;
      if (ctl.capDecide) begin
        offQ <= {curAddr[WIN_BITS-1:2], 2'b00};
        barQ <= barCode;
        lowQ <= {curAddr[6:2], beOffset(dw1Q[3:0])};
        beQ <= dw1Q[3:0];
        cplTagQ <= inData[15:8];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regWrEn <= 1'b0;
      regWrData <= '0;
      unsupPulse <= 1'b0;
      malformPulse <= 1'b0;
    end else begin
      regWrEn <= ctl.fireWr;
      if (ctl.fireWr) regWrData <= inData;
      unsupPulse <= ctl.flagUnsup;
      malformPulse <= ctl.flagMal;
    end
  end

  assign regWrAddr   = offQ;
  assign regWrBe     = beQ;
  assign regWrBar    = barQ;
  assign descReqId   = dw1Q[31:16];
  assign descTag     = dw1Q[15:8];
  assign descTc      = dw0Q[22:20];
  assign descAttr    = dw0Q[13:12];
  assign descLenDw   = dw0Q[9:0];
  assign descLowAddr = lowQ;
  assign descOffset  = offQ;
  assign descBar     = barQ;
  assign dmaValid    = ctl.passCpl & inValid;
  assign dmaData     = inData;
  assign dmaLast     = inLast;
  assign dmaTag      = cplTagQ;
endmodule

// File: rtl/tlp_rx_ctrl.sv
module tlp_rx_ctrl
  import tlp_rx_pkg::*;
(
  input  logic  clk,
  input  logic  rstN,
  input  logic  inValid,
  input  logic  inLast,
  input  logic  dmaReady,
  input  logic  descReady,
  input  kind_e curKind,
  input  kind_e hdrKind,
  input  logic  hdr4dw,
  input  logic  lenIsOne,
  input  logic  anyHit,
  output ctl_t  ctl,
  output logic  inReady,
  output logic  descValid
);
  typedef enum logic [2:0] {S_IDLE, S_HDR, S_WDATA, S_CPL, S_DROP, S_DESC} state_e;

  state_e stateQ, stateN;
  logic [1:0] beatQ, beatN;
  logic fire, finalHdr;

  always_comb begin
    case (stateQ)
      S_DESC:  inReady = 1'b0;
      S_CPL:   inReady = dmaReady;
      default: inReady = 1'b1;
    endcase
  end

  assign fire      = inValid & inReady;
  assign finalHdr  = (beatQ == (hdr4dw ? 2'd3 : 2'd2));
  assign descValid = (stateQ == S_DESC);

  always_comb begin
    ctl = '0;
    ctl.passCpl = (stateQ == S_CPL);
    stateN = stateQ;
    beatN = beatQ;
    case (stateQ)
      S_IDLE: if (fire) begin
        if (curKind == K_BAD) begin
          ctl.flagUnsup = 1'b1;
          stateN = inLast ? S_IDLE : S_DROP;
        end else if (inLast) begin
          ctl.flagMal = 1'b1;
        end else begin
          ctl.capDw0 = 1'b1;
          beatN = 2'd1;
          stateN = S_HDR;
        end
      end
      S_HDR: if (fire) begin
        ctl.capDw1 = (beatQ == 2'd1);
        ctl.capDw2 = (beatQ == 2'd2);
        if (!finalHdr) begin
          beatN = beatQ + 2'd1;
          if (inLast) begin
            ctl.flagMal = 1'b1;
            stateN = S_IDLE;
          end
        end else begin
          case (hdrKind)
            K_MRD: begin
              if (!anyHit) begin
                ctl.flagUnsup = 1'b1;
                stateN = inLast ? S_IDLE : S_DROP;
              end else if (!inLast) begin
                ctl.flagMal = 1'b1;
                stateN = S_DROP;
              end else begin
                ctl.capDecide = 1'b1;
                stateN = S_DESC;
              end
            end
            K_MWR: begin
              if (!anyHit) begin
                ctl.flagUnsup = 1'b1;
                stateN = inLast ? S_IDLE : S_DROP;
              end else if (inLast) begin
                ctl.flagMal = 1'b1;
                stateN = S_IDLE;
              end else if (!lenIsOne) begin
                ctl.flagMal = 1'b1;
                stateN = S_DROP;
              end else begin
                ctl.capDecide = 1'b1;
                stateN = S_WDATA;
              end
            end
            default: begin
              if (inLast) begin
                ctl.flagMal = 1'b1;
                stateN = S_IDLE;
              end else begin
                ctl.capDecide = 1'b1;
                stateN = S_CPL;
              end
            end
          endcase
        end
      end
      S_WDATA: if (fire) begin
        if (inLast) begin
          ctl.fireWr = 1'b1;
          stateN = S_IDLE;
        end else begin
          ctl.flagMal = 1'b1;
          stateN = S_DROP;
        end
      end
      S_CPL:  if (fire && inLast) stateN = S_IDLE;
      S_DROP: if (fire && inLast) stateN = S_IDLE;
      S_DESC: if (descReady) stateN = S_IDLE;
      default: stateN = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= S_IDLE;
      beatQ <= '0;
    end else begin
      stateQ <= stateN;
      beatQ <= beatN;
    end
  end
endmodule

// File: rtl/tlp_rx_dispatch.sv
module tlp_rx_dispatch
  import tlp_rx_pkg::*;
#(
  parameter int          WIN_BITS  = 12,
  parameter logic [63:0] BAR0_BASE = 64'h0000_0000_F000_0000,
  parameter logic [63:0] BAR2_BASE = 64'h0000_0000_F001_0000,
  parameter logic [63:0] BAR4_BASE = 64'h0000_0010_0000_0000
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [31:0]         inData,
  input  logic                inValid,
  input  logic                inLast,
  output logic                inReady,
  output logic                regWrEn,
  output logic [WIN_BITS-1:0] regWrAddr,
  output logic [31:0]         regWrData,
  output logic [3:0]          regWrBe,
  output logic [2:0]          regWrBar,
  output logic                descValid,
  input  logic                descReady,
  output logic [15:0]         descReqId,
  output logic [7:0]          descTag,
  output logic [2:0]          descTc,
  output logic [1:0]          descAttr,
  output logic [9:0]          descLenDw,
  output logic [6:0]          descLowAddr,
  output logic [WIN_BITS-1:0] descOffset,
  output logic [2:0]          descBar,
  output logic                dmaValid,
  input  logic                dmaReady,
  output logic [31:0]         dmaData,
  output logic                dmaLast,
  output logic [7:0]          dmaTag,
  output logic                unsupPulse,
  output logic                malformPulse
);
  ctl_t  ctl;
  kind_e curKind, hdrKind;
  logic  hdr4dw, lenIsOne, anyHit;

  tlp_rx_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inLast(inLast),
    .dmaReady(dmaReady), .descReady(descReady), .curKind(curKind),
    .hdrKind(hdrKind), .hdr4dw(hdr4dw), .lenIsOne(lenIsOne), .anyHit(anyHit),
    .ctl(ctl), .inReady(inReady), .descValid(descValid)
  );

  tlp_rx_datapath #(
    .WIN_BITS(WIN_BITS), .BAR0_BASE(BAR0_BASE),
    .BAR2_BASE(BAR2_BASE), .BAR4_BASE(BAR4_BASE)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .inData(inData), .inValid(inValid),
    .inLast(inLast), .curKind(curKind), .hdrKind(hdrKind), .hdr4dw(hdr4dw),
    .lenIsOne(lenIsOne), .anyHit(anyHit), .regWrEn(regWrEn),
    .regWrAddr(regWrAddr), .regWrData(regWrData), .regWrBe(regWrBe),
    .regWrBar(regWrBar), .descReqId(descReqId), .descTag(descTag),
    .descTc(descTc), .descAttr(descAttr), .descLenDw(descLenDw),
    .descLowAddr(descLowAddr), .descOffset(descOffset), .descBar(descBar),
    .dmaValid(dmaValid), .dmaData(dmaData), .dmaLast(dmaLast),
    .dmaTag(dmaTag), .unsupPulse(unsupPulse), .malformPulse(malformPulse)
  );
endmodule

// File: rtl/tlp_rx_checker.sv
module tlp_rx_checker #(
  parameter int WIN_BITS = 12
) (
  input logic                clk,
  input logic                rstN,
  input logic                inValid,
  input logic                inLast,
  input logic                inReady,
  input logic                regWrEn,
  input logic [2:0]          regWrBar,
  input logic                descValid,
  input logic                descReady,
  input logic [15:0]         descReqId,
  input logic [7:0]          descTag,
  input logic [WIN_BITS-1:0] descOffset,
  input logic                dmaValid,
  input logic                dmaReady,
  input logic                unsupPulse,
  input logic                malformPulse
);
  // R6: input is stalled while a descriptor waits
  p_stall_desc_r6: assert property (@(posedge clk) disable iff (!rstN)
    descValid |-> !inReady);

  // R6: descriptor stays put until taken
  p_hold_desc_r6: assert property (@(posedge clk) disable iff (!rstN)
    descValid && !descReady |=> descValid && $stable(descReqId) &&
                                $stable(descTag) && $stable(descOffset));

  // R3: a write strobe only follows an accepted final beat
  p_wr_after_last_r3: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |-> $past(inValid && inReady && inLast));

  // R7: window codes are 0, 2 or 4
  p_bar_code_r7: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |-> (regWrBar == 3'd0 || regWrBar == 3'd2 || regWrBar == 3'd4));

  // R9: payload backpressure follows the DMA port
  p_dma_bp_r9: assert property (@(posedge clk) disable iff (!rstN)
    dmaValid |-> inValid && (inReady == dmaReady));

  // R10: a packet raises at most one kind of flag
  p_flag_excl_r10: assert property (@(posedge clk) disable iff (!rstN)
    !(unsupPulse && malformPulse));
endmodule

bind tlp_rx_dispatch tlp_rx_checker #(.WIN_BITS(WIN_BITS)) u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inLast(inLast),
  .inReady(inReady), .regWrEn(regWrEn), .regWrBar(regWrBar),
  .descValid(descValid), .descReady(descReady), .descReqId(descReqId),
  .descTag(descTag), .descOffset(descOffset), .dmaValid(dmaValid),
  .dmaReady(dmaReady), .unsupPulse(unsupPulse), .malformPulse(malformPulse)
);

// File: tb/sim_tlp_rx_dispatch.sv
`timescale 1ns/1ps
module sim_tlp_rx_dispatch;
  localparam int WB = 12;

  logic clk = 1'b0, rstN = 1'b0;
  logic [31:0] inData = '0;
  logic inValid = 1'b0, inLast = 1'b0, inReady;
  logic regWrEn; logic [WB-1:0] regWrAddr; logic [31:0] regWrData;
  logic [3:0] regWrBe; logic [2:0] regWrBar;
  logic descValid, descReady = 1'b0;
  logic [15:0] descReqId; logic [7:0] descTag; logic [2:0] descTc;
  logic [1:0] descAttr; logic [9:0] descLenDw; logic [6:0] descLowAddr;
  logic [WB-1:0] descOffset; logic [2:0] descBar;
  logic dmaValid, dmaReady = 1'b1, dmaLast; logic [31:0] dmaData; logic [7:0] dmaTag;
  logic unsupPulse, malformPulse;

  tlp_rx_dispatch u0 (.*);

  always #2.5 clk = ~clk;

  int checks = 0, failures = 0;
  int wrCnt = 0, unsCnt = 0, malCnt = 0, dmaCnt = 0, descCnt = 0;
  int holdNeg = 0, holdViol = 0, ackDelay = 2, holdCnt = 0, cyc = 0;
  bit bpOn = 0, descSeen = 0;
  logic [31:0] wData; logic [WB-1:0] wAddr; logic [3:0] wBe; logic [2:0] wBar;
  logic [31:0] dLog [16]; logic dLastLog [16]; logic [7:0] dTag;
  logic [15:0] qReq; logic [7:0] qTag; logic [2:0] qTc, qBar; logic [1:0] qAttr;
  logic [9:0] qLen; logic [6:0] qLow; logic [WB-1:0] qOff;
  logic [31:0] pkt [8]; int pktLen;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitors, away from the active edge
  always @(negedge clk) begin
    if (regWrEn) begin
      wrCnt++; wData = regWrData; wAddr = regWrAddr; wBe = regWrBe; wBar = regWrBar;
    end
    if (unsupPulse) unsCnt++;
    if (malformPulse) malCnt++;
    if (dmaValid && dmaReady) begin
      dLog[dmaCnt % 16] = dmaData; dLastLog[dmaCnt % 16] = dmaLast; dTag = dmaTag; dmaCnt++;
    end
    if (descValid) begin
      holdNeg++;
      if (inReady) holdViol++;
      if (!descSeen) begin
        descSeen = 1; descCnt++;
        qReq = descReqId; qTag = descTag; qTc = descTc; qAttr = descAttr;
        qLen = descLenDw; qLow = descLowAddr; qOff = descOffset; qBar = descBar;
      end
    end else descSeen = 0;
  end

  // responders for the descriptor and DMA ports
  always @(posedge clk) begin
    #1;
    cyc++;
    dmaReady = !bpOn || (cyc % 3 != 0);
    if (descValid) begin
      holdCnt++;
      descReady = (holdCnt >= ackDelay);
    end else begin
      holdCnt = 0;
      descReady = 0;
    end
  end

  task automatic sendBeat(input logic [31:0] d, input logic l);
    logic rdy;
    inValid = 1; inData = d; inLast = l;
    do begin
      @(negedge clk); rdy = inReady;
      @(posedge clk); #1;
    end while (!rdy);
    inValid = 0; inLast = 0;
  endtask

  task automatic sendPkt();
    for (int i = 0; i < pktLen; i++) sendBeat(pkt[i], i == pktLen - 1);
    repeat (ackDelay + 4) begin @(posedge clk); #1; end
  endtask

  function automatic int expKind(input logic [7:0] c); // 0 rd,1 wr,2 cpl,3 bad
    if (c == 8'h00 || c == 8'h20) return 0;
    if (c == 8'h40 || c == 8'h60) return 1;
    if (c == 8'h4A) return 2;
    return 3;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int w0, u0c, m0, d0, q0, hn;
    logic [7:0] c;
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    @(negedge clk);
    check("R1 reset outputs", {inReady, descValid, regWrEn, dmaValid, unsupPulse, malformPulse},
          {1'b1, 5'b0});
    @(posedge clk); #1;

    // R2 sweep of every format/type byte
    for (int k = 0; k < 256; k++) begin
      int n, ek;
      c = k[7:0];
      ek = expKind(c);
      n = 0;
      pkt[n++] = {c, 14'b0, 10'd1};
      pkt[n++] = 32'hABCD_120F;
      if (c[5]) pkt[n++] = 32'h0;
      pkt[n++] = 32'hF000_0040;
      if (c[6]) pkt[n++] = 32'h1000_0000 + k;
      pktLen = n;
      w0 = wrCnt; u0c = unsCnt; m0 = malCnt; d0 = dmaCnt; q0 = descCnt;
      sendPkt();
      check($sformatf("R2 classify code %0h", c),
            {8'(descCnt - q0), 8'(wrCnt - w0), 8'(dmaCnt - d0), 8'(unsCnt - u0c), 8'(malCnt - m0)},
            {8'(ek == 0), 8'(ek == 1), 8'(ek == 2), 8'(ek == 3), 8'd0});
      if (ek == 1) check("R3 sweep write data/offset/bar", {wData, 20'(wAddr), wBar}, {32'h1000_0000 + k, 20'h40, 3'd0});
      if (ek == 0) check("R5 sweep desc id/tag/offset", {qReq, qTag, 20'(qOff)}, {16'hABCD, 8'h12, 20'h40});
    end

    // R3 R7: write at top of BAR2 window
    pkt[0] = 32'h4000_0001; pkt[1] = 32'h0000_0003; pkt[2] = 32'hF001_0FFC; pkt[3] = 32'hDEAD_BEEF;
    pktLen = 4; w0 = wrCnt; sendPkt();
    check("R3 write count", wrCnt - w0, 1);
    check("R3 R7 write fields", {wData, 20'(wAddr), wBe, wBar}, {32'hDEAD_BEEF, 20'hFFC, 4'h3, 3'd2});

    // R7: one byte past BAR0 window
    pkt[2] = 32'hF000_1000; u0c = unsCnt; w0 = wrCnt; sendPkt();
    check("R7 window miss", {unsCnt - u0c, wrCnt - w0}, {32'd1, 32'd0});

    // R8: 4DW write into BAR4
    pkt[0] = 32'h6000_0001; pkt[1] = 32'h0000_000F; pkt[2] = 32'h0000_0010;
    pkt[3] = 32'h0000_0008; pkt[4] = 32'h5555_AAAA; pktLen = 5; w0 = wrCnt; sendPkt();
    check("R8 4DW write to upper window", {32'(wrCnt - w0), wData, 20'(wAddr), wBar},
          {32'd1, 32'h5555_AAAA, 20'h8, 3'd4});

    // R8: 3DW cannot reach BAR4
    pkt[0] = 32'h0000_0001; pkt[1] = 32'h0000_000F; pkt[2] = 32'h0000_0008; pktLen = 3;
    u0c = unsCnt; q0 = descCnt; sendPkt();
    check("R8 3DW upper bits zero", {unsCnt - u0c, descCnt - q0}, {32'd1, 32'd0});

    // R4: two-DW write to a window
    pkt[0] = 32'h4000_0002; pkt[1] = 32'h0000_00FF; pkt[2] = 32'hF000_0010;
    pkt[3] = 32'h1; pkt[4] = 32'h2; pktLen = 5; m0 = malCnt; w0 = wrCnt; sendPkt();
    check("R4 long write rejected", {malCnt - m0, wrCnt - w0}, {32'd1, 32'd0});

    // R5 R6: read with delayed acknowledge
    ackDelay = 5; hn = holdNeg; holdViol = 0;
    pkt[0] = {8'h00, 1'b0, 3'd5, 6'b0, 2'd2, 2'b0, 10'd7};
    pkt[1] = 32'h1234_56FC; pkt[2] = 32'hF000_0AB8; pktLen = 3; q0 = descCnt; sendPkt();
    check("R5 desc count", descCnt - q0, 1);
    check("R5 desc fields", {qReq, qTag, 1'b0, qTc, 2'b0, qAttr, 6'b0, qLen},
          {16'h1234, 8'h56, 1'b0, 3'd5, 2'b0, 2'd2, 6'b0, 10'd7});
    check("R5 desc low addr/offset/bar", {qLow, 20'(qOff), qBar}, {7'h3A, 20'hAB8, 3'd0});
    check("R6 hold length", holdNeg - hn, 5);
    check("R6 input stalled while held", holdViol, 0);
    ackDelay = 2;

    // R9: completion payload under backpressure
    bpOn = 1;
    pkt[0] = 32'h4A00_0004; pkt[1] = 32'h0100_0010; pkt[2] = 32'h0000_9C00;
    for (int i = 0; i < 4; i++) pkt[3 + i] = 32'hC0DE_0000 + i;
    pktLen = 7; d0 = dmaCnt; sendPkt();
    bpOn = 0;
    check("R9 beat count", dmaCnt - d0, 4);
    for (int i = 0; i < 4; i++)
      check($sformatf("R9 beat %0d data/last", i), {dLog[(d0 + i) % 16], 31'b0, dLastLog[(d0 + i) % 16]},
            {32'hC0DE_0000 + i, 31'b0, 1'(i == 3)});
    check("R9 tag", dTag, 8'h9C);

    // R10: truncated header
    pkt[0] = 32'h4000_0001; pkt[1] = 32'h0000_000F; pktLen = 2; m0 = malCnt; w0 = wrCnt; sendPkt();
    check("R10 truncated header", {malCnt - m0, wrCnt - w0}, {32'd1, 32'd0});
    pktLen = 1; m0 = malCnt; sendPkt();
    check("R10 lone DW0", malCnt - m0, 1);

    // R10: read with trailing beat
    pkt[0] = 32'h0000_0001; pkt[1] = 32'h0000_000F; pkt[2] = 32'hF000_0004; pkt[3] = 32'h9;
    pktLen = 4; m0 = malCnt; q0 = descCnt; sendPkt();
    check("R10 read with extra beat", {malCnt - m0, descCnt - q0}, {32'd1, 32'd0});

    // R10: single-DW write followed by an extra beat
    pkt[0] = 32'h4000_0001; pkt[2] = 32'hF000_0004; pkt[3] = 32'h7; pkt[4] = 32'h8;
    pktLen = 5; m0 = malCnt; w0 = wrCnt; sendPkt();
    check("R10 write with extra beat", {malCnt - m0, wrCnt - w0}, {32'd1, 32'd0});

    // R11: drained payload looks like a header; next packet still decoded
    pkt[0] = 32'h7000_0003; pkt[1] = 32'h4000_0001; pkt[2] = 32'h0000_000F;
    pkt[3] = 32'hF000_0020; pkt[4] = 32'h4000_0001; pktLen = 5;
    u0c = unsCnt; w0 = wrCnt; m0 = malCnt; sendPkt();
    pkt[0] = 32'h4000_0001; pkt[1] = 32'h0000_000F; pkt[2] = 32'hF000_0020; pkt[3] = 32'h7777_0000;
    pktLen = 4; sendPkt();
    check("R11 drain then resume", {unsCnt - u0c, wrCnt - w0, malCnt - m0}, {32'd1, 32'd1, 32'd0});
    check("R11 resumed write data", wData, 32'h7777_0000);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule